// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block drives an external edge-triggered 12-bit sampling converter from a synchronous system clock. It fires a start-convert pulse of fixed minimum width at a programmable interval, never faster than the converter's 1.2 MHz throughput limit. It then follows the asynchronous end-of-conversion line through a synchronizer. Once that line drops and a settle interval has passed, it latches the parallel output code. The converter has no pipeline latency, so every conversion that completes yields exactly one sample, tagged with the start that produced it.

Samples leave on a valid/ready stream with a discard flag. A sample is flagged when a start pulse hit the converter while it was still busy, which ruins both the interrupted result and the one after it. It is also flagged when the host asked for warmup conversions, which keep the converter running but carry no useful data. Starts are issued only while the run enable and the power-good input are both high. A stalled stream keeps only the newest sample and raises a sticky overrun flag. An end-of-conversion line that never falls raises a sticky timeout error.

Top module: `adc_seq_top`

## Requirements
- R1: After reset, start_out, smp_valid, overrun and eoc_err are all 0.
- R2: Each start pulse stays high for exactly ceil(100 ns x clock MHz / 1000) cycles, which is 13 cycles at 125 MHz.
- R3: Consecutive start rising edges are max(period_cyc, MIN) cycles apart, where MIN = ceil(clock kHz / 1200), which is 105 at 125 MHz. Rising edges are never closer than MIN cycles, even when running is stopped and restarted.
- R4: A start rising edge occurs only if run_en and pwr_ok were both 1 in the cycle before it. With either one low, no start is issued.
- R5: Every conversion whose end-of-conversion falls yields exactly one sample. smp_data is adc_bits as sampled once the settle interval (ceil(35 ns x clock MHz / 1000) cycles) has passed after the synchronized falling edge. Codes that are present only in the first 30 ns after the fall never appear.
- R6: The code is passed as unsigned straight binary on 12 bits, unchanged, including 0x000 (zero scale) and 0xFFF (full scale minus 1 LSB).
- R7: A start issued while a conversion is still pending abandons that conversion, so it emits no sample. The next two samples emitted carry smp_bad = 1.
- R8: A sample captured while warm_en is 1 carries smp_bad = 1. Conversions continue at the programmed rate throughout warmup.
- R9: If a new sample is captured while smp_valid is 1 and smp_ready is 0, the new sample replaces the old one, and overrun becomes 1 and stays 1 until reset.
- R10: If end-of-conversion is not seen to fall within 250 cycles (2 us at 125 MHz) of the conversion starting, eoc_err becomes 1 and stays 1 until reset, and no sample is emitted for that conversion.
- R11: While smp_valid is 1 and smp_ready is 0, smp_valid stays 1 and smp_data holds its value, unless a new capture replaces it as R9 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Request continuous conversions |
| pwr_ok | input | 1 | All converter supplies are up |
| warm_en | input | 1 | Warmup: keep converting, mark samples for discard |
| period_cyc | input | 16 | Requested start interval in clock cycles |
| eoc_in | input | 1 | Asynchronous end-of-conversion (high = busy) |
| adc_bits | input | 12 | Parallel converter output code |
| start_out | output | 1 | Start-convert pulse to the converter |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Consumer accepts the sample |
| smp_data | output | 12 | Sample code, straight binary |
| smp_bad | output | 1 | Sample must be discarded |
| overrun | output | 1 | Sticky: a sample was overwritten while stalled |
| eoc_err | output | 1 | Sticky: end-of-conversion timeout |

## Verification
The converter model in the bench holds garbage on the data pins for 30 ns after each fall, so a design that captures without the settle wait delivers inverted codes. The bench stretches one conversion past the next start to force a collision. A design that flags only one sample, or emits the abandoned result, then disagrees with the scoreboard. The bench programs a period below the throughput floor and measures the real spacing. It stalls the stream across three captures to show that only the newest sample survives and that overrun sticks. A line stuck high must raise the timeout even though the repeated starts keep restarting the conversion. A design that resets its timeout count on every restart would never report the error.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

  typedef enum logic [1:0] {
    CS_IDLE   = 2'd0,
    CS_CONV   = 2'd1,
    CS_SETTLE = 2'd2
  } cap_st_t;

  // Round a time in ns up to whole clock cycles.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // Smallest start interval in cycles that respects a rate ceiling in kHz.
  function automatic int unsigned rate_to_cyc(input int unsigned mhz, input int unsigned khz);
    return (mhz * 1000 + khz - 1) / khz;
  endfunction

endpackage

// File: rtl/adc_seq_timer.sv
`timescale 1ns/1ps
module adc_seq_timer #(
  parameter int unsigned PER_W     = 16,
  parameter int unsigned PULSE_CYC = 13,
  parameter int unsigned MIN_PER   = 105
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PER_W-1:0] period_in,
  output logic             start_o,
  output logic             fire_o
);
  localparam int unsigned PW_W = $clog2(PULSE_CYC + 1);
  localparam logic [PER_W-1:0] MIN_P = PER_W'(MIN_PER);

  logic [PER_W-1:0] per_cnt;
  logic [PER_W-1:0] eff_per;
  logic [PW_W-1:0]  pw_cnt;

  always_comb eff_per = (period_in < MIN_P) ? MIN_P : period_in;

  // Counter keeps running down while idle so a restart cannot shorten the gap.
  assign fire_o = run && (per_cnt == '0) && !start_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_cnt <= '0;
      pw_cnt  <= '0;
      start_o <= 1'b0;
    end else begin
      if (fire_o)
        per_cnt <= eff_per - 1'b1;
      else if (per_cnt != '0)
        per_cnt <= per_cnt - 1'b1;

      if (fire_o) begin
        start_o <= 1'b1;
        pw_cnt  <= PW_W'(PULSE_CYC - 1);
      end else if (start_o) begin
        if (pw_cnt == '0) start_o <= 1'b0;
        else              pw_cnt  <= pw_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_seq_sync.sv
`timescale 1ns/1ps
module adc_seq_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_o,
  output logic fall_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= async_in;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign level_o = s2;
  assign fall_o  = s3 && !s2;
endmodule

// File: rtl/adc_seq_capture.sv
`timescale 1ns/1ps
module adc_seq_capture
  import adc_seq_pkg::*;
#(
  parameter int unsigned DW         = 12,
  parameter int unsigned SETTLE_CYC = 5,
  parameter int unsigned TMO_CYC    = 250
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          eoc_fall,
  input  logic          warm,
  input  logic [DW-1:0] bits,
  output logic          cap_o,
  output logic [DW-1:0] cap_data,
  output logic          cap_bad,
  output logic          collide_o,
  output logic          err_o
);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
  localparam int unsigned TW = $clog2(TMO_CYC + 1);

  cap_st_t        st;
  logic [SW-1:0]  st_cnt;
  logic [TW-1:0]  tmo;
  logic [1:0]     taint;

  assign collide_o = fire && (st != CS_IDLE);
  assign cap_o     = (st == CS_SETTLE) && (st_cnt == '0) && !fire;
  assign cap_data  = bits;
  assign cap_bad   = (taint != 2'd0) || warm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= CS_IDLE;
      st_cnt <= '0;
      tmo    <= '0;
      taint  <= 2'd0;
      err_o  <= 1'b0;
    end else begin
      if (fire) begin
        st <= CS_CONV;
        // A restart during a conversion keeps the elapsed time.
        if (st != CS_CONV) tmo <= '0;
      end else begin
        unique case (st)
          CS_CONV: begin
            if (eoc_fall) begin
              st     <= CS_SETTLE;
              st_cnt <= SW'(SETTLE_CYC - 1);
            end else if (tmo == TW'(TMO_CYC - 1)) begin
              st    <= CS_IDLE;
              err_o <= 1'b1;
            end else begin
              tmo <= tmo + 1'b1;
            end
          end
          CS_SETTLE: begin
            if (st_cnt == '0) st <= CS_IDLE;
            else              st_cnt <= st_cnt - 1'b1;
          end
          default: st <= CS_IDLE;
        endcase
      end

      if (collide_o)
        taint <= 2'd2;
      else if (cap_o && taint != 2'd0)
        taint <= taint - 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_skid.sv
`timescale 1ns/1ps
module adc_seq_skid #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          bad_in,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] dout,
  output logic          bad_out,
  output logic          ovr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      dout    <= '0;
      bad_out <= 1'b0;
      ovr     <= 1'b0;
    end else if (load) begin
      dout    <= din;
      bad_out <= bad_in;
      valid   <= 1'b1;
      if (valid && !ready) ovr <= 1'b1;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
`timescale 1ns/1ps
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 125,
  parameter int unsigned PULSE_NS     = 100,
  parameter int unsigned SETTLE_NS    = 35,
  parameter int unsigned MAX_RATE_KHZ = 1200,
  parameter int unsigned TMO_NS       = 2000,
  parameter int unsigned DW           = 12,
  parameter int unsigned PER_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             pwr_ok,
  input  logic             warm_en,
  input  logic [PER_W-1:0] period_cyc,
  input  logic             eoc_in,
  input  logic [DW-1:0]    adc_bits,
  output logic             start_out,
  output logic             smp_valid,
  input  logic             smp_ready,
  output logic [DW-1:0]    smp_data,
  output logic             smp_bad,
  output logic             overrun,
  output logic             eoc_err
);
  localparam int unsigned PULSE_CYC  = ns_to_cyc(PULSE_NS, CLK_MHZ);
  localparam int unsigned SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_MHZ);
  localparam int unsigned TMO_CYC    = ns_to_cyc(TMO_NS, CLK_MHZ);
  localparam int unsigned MIN_PER    = rate_to_cyc(CLK_MHZ, MAX_RATE_KHZ);

  // Internal events, named for the checker.
  logic          fire_evt;
  logic          collide_evt;
  logic          cap_evt;
  logic          eoc_fall_evt;
  logic          eoc_lvl;
  logic [DW-1:0] cap_data;
  logic          cap_bad;
  logic          run;

  assign run = run_en && pwr_ok;

  adc_seq_timer #(
    .PER_W(PER_W), .PULSE_CYC(PULSE_CYC), .MIN_PER(MIN_PER)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .period_in(period_cyc),
    .start_o(start_out), .fire_o(fire_evt)
  );

  adc_seq_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(eoc_in),
    .level_o(eoc_lvl), .fall_o(eoc_fall_evt)
  );

  adc_seq_capture #(
    .DW(DW), .SETTLE_CYC(SETTLE_CYC), .TMO_CYC(TMO_CYC)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .fire(fire_evt), .eoc_fall(eoc_fall_evt),
    .warm(warm_en), .bits(adc_bits), .cap_o(cap_evt), .cap_data(cap_data),
    .cap_bad(cap_bad), .collide_o(collide_evt), .err_o(eoc_err)
  );

  adc_seq_skid #(.DW(DW)) u_skid (
    .clk(clk), .rst_n(rst_n), .load(cap_evt), .din(cap_data), .bad_in(cap_bad),
    .ready(smp_ready), .valid(smp_valid), .dout(smp_data), .bad_out(smp_bad),
    .ovr(overrun)
  );
endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk #(
  parameter int unsigned PER_W     = 16,
  parameter int unsigned PULSE_CYC = 13,
  parameter int unsigned MIN_PER   = 105
) (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic pwr_ok,
  input logic start_out,
  input logic smp_valid,
  input logic smp_ready,
  input logic overrun,
  input logic eoc_err,
  input logic cap_evt,
  input logic fire_evt,
  input logic collide_evt
);
  logic [PER_W-1:0] hi_cnt;
  logic [PER_W-1:0] gap;
  logic             seen;
  logic             st_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0;
      gap    <= '0;
      seen   <= 1'b0;
      st_d   <= 1'b0;
    end else begin
      st_d   <= start_out;
      hi_cnt <= start_out ? hi_cnt + 1'b1 : '0;
      if (start_out && !st_d) begin
        gap  <= PER_W'(1);
        seen <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start_out) |-> hi_cnt == PER_W'(PULSE_CYC));

  // R3
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(start_out) && seen) |-> gap >= PER_W'(MIN_PER));

  // R4
  start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_out) |-> $past(run_en && pwr_ok));

  // R5
  cap_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> smp_valid);

  // R7
  collide_no_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    collide_evt |-> (fire_evt && !cap_evt));

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R10
  eoc_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_err |=> eoc_err);

  // R11
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> smp_valid);
endmodule

bind adc_seq_top adc_seq_chk #(
  .PER_W(PER_W), .PULSE_CYC(PULSE_CYC), .MIN_PER(MIN_PER)
) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .pwr_ok(pwr_ok),
  .start_out(start_out), .smp_valid(smp_valid), .smp_ready(smp_ready),
  .overrun(overrun), .eoc_err(eoc_err), .cap_evt(cap_evt),
  .fire_evt(fire_evt), .collide_evt(collide_evt)
);

// File: tb/test_adc_seq_top.sv
`timescale 1ns/1ps
module test_adc_seq_top;
  logic        clk = 1'b0;
  logic        rst_n, run_en, pwr_ok, warm_en, smp_ready;
  logic [15:0] period_cyc;
  logic        eoc_m;
  logic [11:0] adc_bits;
  logic        start_out, smp_valid, smp_bad, overrun, eoc_err;
  logic [11:0] smp_data;

  always #4 clk = ~clk;

  adc_seq_top i_adc_seq_top (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .pwr_ok(pwr_ok),
    .warm_en(warm_en), .period_cyc(period_cyc), .eoc_in(eoc_m),
    .adc_bits(adc_bits), .start_out(start_out), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .smp_bad(smp_bad),
    .overrun(overrun), .eoc_err(eoc_err)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // ---------------- converter model and scoreboard driver ----------------
  logic [12:0] exp_q[$];
  event        pushed;
  int          gen = 0;
  int          conv_idx = 0;
  int          btaint = 0;
  bit          stuck = 1'b0;
  bit          stretch = 1'b0;

  function automatic logic [11:0] code_of(input int k);
    if (k % 7 == 2) return 12'h000;
    if (k % 7 == 5) return 12'hFFF;
    return 12'((k * 1237 + 291) & 32'hFFF);
  endfunction

  task automatic run_conv(input int g, input int dns);
    logic [11:0] v;
    #10;
    eoc_m = 1'b1;
    #(dns);
    if (g == gen) begin
      v = code_of(conv_idx);
      conv_idx++;
      eoc_m    = 1'b0;
      adc_bits = ~v;
      exp_q.push_back({(btaint > 0) || warm_en, v});
      if (btaint > 0) btaint--;
      ->pushed;
      #30;
      adc_bits = v;
    end
  endtask

  always @(posedge start_out) begin
    gen++;
    if (stuck) begin
      eoc_m = 1'b1;
    end else begin
      int d;
      if (eoc_m) btaint = 2;        // start while busy (R7)
      d = stretch ? 1500 : 420;
      stretch = 1'b0;
      fork
        run_conv(gen, d);
      join_none
    end
  end

  // ---------------- monitor ----------------
  int pops = 0, bad_pops = 0;
  bit saw_zero = 1'b0, saw_full = 1'b0;

  always @(negedge clk) begin
    if (rst_n && smp_valid && smp_ready) begin
      pops++;
      if (smp_bad) bad_pops++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "sample with no conversion", int'(smp_data), -1);
      end else begin
        logic [12:0] e;
        e = exp_q.pop_front();
        chk(smp_data == e[11:0], "R5 R6", "sample code", int'(smp_data), int'(e[11:0]));
        chk(smp_bad == e[12], "R7 R8", "discard flag", int'(smp_bad), int'(e[12]));
        if (smp_data == e[11:0] && e[11:0] == 12'h000) saw_zero = 1'b1;
        if (smp_data == e[11:0] && e[11:0] == 12'hFFF) saw_full = 1'b1;
      end
    end
  end

  // start pulse width and spacing
  int rises = 0, since = 0, hi_run = 0, last_w = 0, last_per = 0;
  logic st_prev = 1'b0;
  always @(negedge clk) begin
    if (start_out) hi_run++;
    if (!start_out && st_prev) begin last_w = hi_run; hi_run = 0; end
    if (start_out && !st_prev) begin last_per = since; since = 1; rises++; end
    else since++;
    st_prev = start_out;
  end

  task automatic after_sample();
    @(pushed);
    repeat (20) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int r0, p0, b0;
    rst_n = 1'b0; run_en = 1'b0; pwr_ok = 1'b0; warm_en = 1'b0;
    smp_ready = 1'b1; period_cyc = 16'd150; eoc_m = 1'b0; adc_bits = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(start_out == 1'b0, "R1", "start after reset", int'(start_out), 0);
    chk(smp_valid == 1'b0, "R1", "valid after reset", int'(smp_valid), 0);
    chk(overrun == 1'b0, "R1", "overrun after reset", int'(overrun), 0);
    chk(eoc_err == 1'b0, "R1", "eoc_err after reset", int'(eoc_err), 0);
    rst_n = 1'b1;

    // R4: no supplies, no starts
    run_en = 1'b1;
    repeat (400) @(negedge clk);
    chk(rises == 0, "R4", "starts with pwr_ok low", rises, 0);

    // R8: warmup conversions keep running, all flagged
    warm_en = 1'b1; pwr_ok = 1'b1;
    b0 = bad_pops;
    repeat (4) @(pushed);
    repeat (20) @(negedge clk);
    chk(last_w == 13, "R2", "start pulse width", last_w, 13);
    chk(last_per == 150, "R3", "programmed period", last_per, 150);
    chk(bad_pops - b0 == 4, "R8", "warmup samples flagged", bad_pops - b0, 4);
    warm_en = 1'b0;

    // R5/R6: normal samples over the code range
    repeat (8) @(pushed);
    repeat (20) @(negedge clk);

    // R3: period below the throughput floor is clamped
    period_cyc = 16'd10;
    repeat (4) @(pushed);
    repeat (20) @(negedge clk);
    chk(last_per == 105, "R3", "clamped period", last_per, 105);
    period_cyc = 16'd150;
    after_sample();

    // R7: one stretched conversion gets hit by the next start
    b0 = bad_pops; p0 = pops;
    stretch = 1'b1;
    repeat (4) @(pushed);
    repeat (20) @(negedge clk);
    chk(bad_pops - b0 == 2, "R7", "samples flagged after collision", bad_pops - b0, 2);
    chk(pops - p0 == 4, "R7", "samples after collision", pops - p0, 4);
    chk(eoc_err == 1'b0, "R10", "no false timeout", int'(eoc_err), 0);

    // R9/R11: stall across three captures
    chk(overrun == 1'b0, "R9", "overrun before stall", int'(overrun), 0);
    smp_ready = 1'b0;
    repeat (3) @(pushed);
    repeat (20) @(negedge clk);
    chk(smp_valid == 1'b1, "R11", "valid held while stalled", int'(smp_valid), 1);
    chk(overrun == 1'b1, "R9", "overrun set", int'(overrun), 1);
    while (exp_q.size() > 1) void'(exp_q.pop_front());
    smp_ready = 1'b1;
    after_sample();
    chk(overrun == 1'b1, "R9", "overrun sticky", int'(overrun), 1);

    // R4: run_en low stops starts
    run_en = 1'b0;
    r0 = rises;
    repeat (400) @(negedge clk);
    chk(rises == r0, "R4", "starts with run_en low", rises - r0, 0);
    chk(exp_q.size() == 0, "R5", "all conversions delivered", exp_q.size(), 0);
    chk(saw_zero && saw_full, "R6", "zero and full scale codes seen",
        int'(saw_zero) + int'(saw_full), 2);

    // R10: end-of-conversion stuck high
    chk(eoc_err == 1'b0, "R10", "eoc_err before stuck", int'(eoc_err), 0);
    stuck = 1'b1;
    p0 = pops;
    run_en = 1'b1;
    repeat (600) @(negedge clk);
    chk(eoc_err == 1'b1, "R10", "timeout raised", int'(eoc_err), 1);
    chk(pops == p0, "R10", "no sample from stuck conversion", pops - p0, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule